// File: doc/BRIEF.md
# Configuration Register CRC Integrity Monitor

This block watches a bank of configuration words while the device is running, so that a silent change to any of them is caught. When the device moves from its configuration state into its active state, the monitor reads every protected word once, folds the words into a CRC-8 signature and keeps that signature as the baseline. It then keeps reading the whole bank again, one sweep after another, and compares each new signature with the baseline. If the two differ, it raises a sticky fault. The fault also appears at bit 4 of a status word.

The register file itself lives outside the block. The monitor drives a read address into the bank and takes back the data word for that address in the same cycle. A test word sits inside the protected set, so writing a different value to it while the device is active is a deliberate way to provoke the fault. Writes made in configuration state are never compared, so they never cause a fault. Whenever the device re-enters active state, a fresh baseline is taken first.

Top module: `cfgcrc_monitor`

## Requirements
- R1: After a synchronous reset, `fault` is 0, `stat_word` is 0 and `rd_addr` is 0.
- R2: The signature is CRC-8 with polynomial 0x07, seeded with 0xFF, no reflection and no final XOR. It is fed MSB first, word 0 to word NUM_REGS-1, and the upper byte of each word goes in first.
- R3: While monitoring, `rd_addr` steps through 0 to NUM_REGS-1, one address per cycle. It then holds 0 for SWEEP_GAP cycles, and the next sweep begins. In the cycle after monitoring starts, the first sweep is presented with `rd_addr` = 0.
- R4: The first sweep after monitoring starts stores its signature as the baseline and never raises the fault.
- R5: A later sweep whose signature differs from the baseline sets `fault` on the clock edge that consumes its last word.
- R6: A changed value written to the highest-address word (the test word) during monitoring leads to a fault.
- R7: Monitoring runs only while `act_mode` is 1. With `act_mode` at 0, `rd_addr` stays 0, no comparison is made and bank writes never set `fault`.
- R8: Monitoring also requires `crc_off` to be 0. With `crc_off` at 1, the block behaves as it does in configuration state.
- R9: When monitoring stops, any sweep in progress is abandoned and the baseline is discarded. When monitoring starts again, a new baseline is taken, so changes made in the meantime do not fault.
- R10: `fault` stays set until a `fault_clr` pulse clears it. A mismatch in the same cycle wins over the clear. Clearing the fault does not recapture the baseline, so a lasting change faults again on the next sweep.
- R11: `stat_word` bit 4 equals `fault`, and every other bit of it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| act_mode | input | 1 | 1 = active state, 0 = configuration state |
| crc_off | input | 1 | 1 = monitor disabled |
| fault_clr | input | 1 | Clears the sticky fault |
| rd_data | input | DATA_W | Bank word at `rd_addr`, same cycle |
| rd_addr | output | ADDR_W | Bank read address |
| fault | output | 1 | Sticky configuration-CRC fault |
| stat_word | output | 16 | Status word, fault at bit 4 |

## Verification
The bench builds the block with NUM_REGS = 6 and SWEEP_GAP = 3, so each sweep-plus-gap cycle is 9 clocks long. With that setting, dozens of baseline captures, re-entries into active state, aborted sweeps and clear/re-fault sequences fit in a few hundred cycles. A behavioural model tracks the sweep position and computes its own CRC, which fixes the cycle at which the fault must rise. Single-bit and two-bit changes keep every injected corruption detectable by the chosen polynomial.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SWEEP = 2'd1,
    SQ_GAP   = 2'd2
  } sq_state_t;

  // One byte into a CRC-8, MSB first, no reflection.
  function automatic logic [7:0] crc8_byte(input logic [7:0] cur,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic       fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/cfgcrc_engine.sv
// Folds one bank word into a running CRC-8, upper byte first.
module cfgcrc_engine #(
  parameter int         DATA_W = 16,
  parameter logic [7:0] POLY   = 8'h07
) (
  input  logic [7:0]        crc_in,
  input  logic [DATA_W-1:0] word,
  output logic [7:0]        crc_out
);
  import cfgcrc_pkg::*;

  localparam int NBYTES = DATA_W / 8;

  logic [7:0] chain [NBYTES+1];

  assign chain[0] = crc_in;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign chain[k+1] = crc8_byte(chain[k], word[DATA_W-1-8*k -: 8], POLY);
  end

  assign crc_out = chain[NBYTES];

endmodule

// File: rtl/cfgcrc_sequencer.sv
// Walks the bank address space, then idles for a gap, while run is high.
module cfgcrc_sequencer #(
  parameter int NUM_REGS  = 16,
  parameter int SWEEP_GAP = 64,
  parameter int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [ADDR_W-1:0] addr,
  output logic              beat,
  output logic              first,
  output logic              last
);
  import cfgcrc_pkg::*;

  localparam int                TMR_W    = $clog2(SWEEP_GAP + 1);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);
  localparam logic [TMR_W-1:0]  GAP_END  = TMR_W'(SWEEP_GAP - 1);

  sq_state_t         st;
  logic [TMR_W-1:0]  tmr;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st   <= SQ_IDLE;
      addr <= '0;
      tmr  <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          st   <= SQ_SWEEP;
          addr <= '0;
        end
        SQ_SWEEP: begin
          if (addr == LAST_IDX) begin
            addr <= '0;
            tmr  <= '0;
            st   <= SQ_GAP;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        SQ_GAP: begin
          if (tmr == GAP_END) st <= SQ_SWEEP;
          else                tmr <= tmr + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign beat  = (st == SQ_SWEEP);
  assign first = beat && (addr == '0);
  assign last  = beat && (addr == LAST_IDX);

endmodule

// File: rtl/cfgcrc_monitor.sv
// Baseline capture, comparison and sticky fault for the configuration bank.
module cfgcrc_monitor #(
  parameter int         NUM_REGS  = 16,
  parameter int         DATA_W    = 16,
  parameter int         SWEEP_GAP = 64,
  parameter logic [7:0] POLY      = 8'h07,
  parameter int         ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_mode,
  input  logic              crc_off,
  input  logic              fault_clr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fault,
  output logic [15:0]       stat_word
);
  localparam int         FAULT_BIT = 4;
  localparam logic [7:0] SEED      = 8'hFF;

  logic       run;
  logic       beat, first, last;
  logic [7:0] acc, crc_cur, crc_nxt, base;
  logic       base_vld;
  logic       mis_hit;
  logic       fault_d;

  assign run = act_mode && !crc_off;

  cfgcrc_sequencer #(
    .NUM_REGS (NUM_REGS),
    .SWEEP_GAP(SWEEP_GAP),
    .ADDR_W   (ADDR_W)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .addr (rd_addr),
    .beat (beat),
    .first(first),
    .last (last)
  );

  assign crc_cur = first ? SEED : acc;

  cfgcrc_engine #(
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_eng (
    .crc_in (crc_cur),
    .word   (rd_data),
    .crc_out(crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) acc <= SEED;
    else if (beat) acc <= crc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      base_vld <= 1'b0;
      base     <= SEED;
    end else if (last && !base_vld) begin
      base_vld <= 1'b1;
      base     <= crc_nxt;
    end
  end

  assign mis_hit = run && last && base_vld && (crc_nxt != base);

  always_comb begin
    fault_d = fault;
    if (fault_clr) fault_d = 1'b0;
    if (mis_hit)   fault_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault     <= 1'b0;
      stat_word <= '0;
    end else begin
      fault                <= fault_d;
      stat_word            <= '0;
      stat_word[FAULT_BIT] <= fault_d;
    end
  end

endmodule

// File: rtl/cfgcrc_monitor_chk.sv
module cfgcrc_monitor_chk #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              act_mode,
  input logic              crc_off,
  input logic              fault_clr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              fault,
  input logic [15:0]       stat_word,
  input logic              beat,
  input logic              mis_hit
);

  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    rd_addr < ADDR_W'(NUM_REGS));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (beat && rd_addr != '0) |-> ($past(beat) && rd_addr == $past(rd_addr) + 1'b1));

  p_idle_addr_r7: assert property (@(posedge clk) disable iff (rst)
    !beat |-> rd_addr == '0);

  p_cfg_no_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (!fault && !(act_mode && !crc_off)) |=> !fault);

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    mis_hit |=> fault);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (fault && !fault_clr) |=> fault);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_clr && !mis_hit) |=> !fault);

  p_status_r11: assert property (@(posedge clk) disable iff (rst)
    stat_word[4] == fault && $countones(stat_word) == 32'(fault));

endmodule

bind cfgcrc_monitor cfgcrc_monitor_chk #(
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .act_mode (act_mode),
  .crc_off  (crc_off),
  .fault_clr(fault_clr),
  .rd_addr  (rd_addr),
  .fault    (fault),
  .stat_word(stat_word),
  .beat     (beat),
  .mis_hit  (mis_hit)
);

// File: tb/cfgcrc_monitor_tb.sv
module cfgcrc_monitor_tb;
  localparam int NR  = 6;
  localparam int GAP = 3;
  localparam int AW  = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          act_mode = 1'b0;
  logic          crc_off = 1'b0;
  logic          fault_clr = 1'b0;
  logic [15:0]   bank [NR];
  logic [15:0]   rd_data;
  logic [AW-1:0] rd_addr;
  logic          fault;
  logic [15:0]   stat_word;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  // model state
  int  m_pos = -1;
  int  m_acc = 255;
  int  m_base = 0;
  bit  m_has = 0;
  bit  m_fault = 0;

  always #4 clk = ~clk;

  assign rd_data = bank[rd_addr];

  cfgcrc_monitor #(.NUM_REGS(NR), .DATA_W(16), .SWEEP_GAP(GAP)) u_dut (
    .clk(clk), .rst(rst), .act_mode(act_mode), .crc_off(crc_off),
    .fault_clr(fault_clr), .rd_data(rd_data), .rd_addr(rd_addr),
    .fault(fault), .stat_word(stat_word)
  );

  function automatic int crc_word(int c, int w);
    int r = c;
    for (int by = 1; by >= 0; by--) begin
      int b = (w >> (8 * by)) & 255;
      for (int i = 7; i >= 0; i--) begin
        int fb = ((r >> 7) ^ (b >> i)) & 1;
        r = (r << 1) & 255;
        if (fb != 0) r = r ^ 7;
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_next();
    bit set = 0;
    if (rst) begin
      m_pos = -1; m_acc = 255; m_has = 0; m_fault = 0;
      return;
    end
    if (!(act_mode && !crc_off)) begin
      m_pos = -1; m_has = 0;
    end else if (m_pos < 0) begin
      m_pos = 0; m_acc = 255;
    end else if (m_pos < NR) begin
      m_acc = crc_word(m_acc, int'(bank[m_pos]));
      if (m_pos == NR - 1) begin
        if (!m_has) begin m_base = m_acc; m_has = 1; end
        else if (m_acc != m_base) set = 1;
      end
      m_pos++;
    end else if (m_pos == NR + GAP - 1) begin
      m_pos = 0; m_acc = 255;
    end else begin
      m_pos++;
    end
    if (set) m_fault = 1;
    else if (fault_clr) m_fault = 0;
  endtask

  task automatic step();
    int ea;
    @(negedge clk);
    if (!rst) begin
      ea = (m_pos >= 0 && m_pos < NR) ? m_pos : 0;
      chk("R3 rd_addr", int'(rd_addr), ea);
      chk("R2 R5 fault", int'(fault), int'(m_fault));
      chk("R11 stat_word", int'(stat_word), m_fault ? 16 : 0);
    end
    model_next();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) bank[i] = 16'(16'h0A05 + i * 16'h1131);
    bank[NR-1] = 16'h0000;
    run(3);
    rst = 1'b0;
    #1;
    chk("R1 fault", int'(fault), 0);
    chk("R1 stat_word", int'(stat_word), 0);
    chk("R1 rd_addr", int'(rd_addr), 0);

    // configuration state: writes are never compared
    run(10);
    bank[2] = bank[2] ^ 16'h0001;
    run(20);
    chk("R7 no fault in config", int'(fault), 0);
    chk("R7 addr idle", int'(rd_addr), 0);

    // enter active, baseline then clean sweeps
    act_mode = 1'b1;
    run(30);
    chk("R4 baseline no fault", int'(fault), 0);

    // write test word during active
    bank[NR-1] = 16'h0018;
    run(20);
    chk("R6 test word fault", int'(fault), 1);

    // clear; lasting change faults again
    fault_clr = 1'b1; run(1); fault_clr = 1'b0;
    run(20);
    chk("R10 refault after clear", int'(fault), 1);
    run(5);
    chk("R10 sticky", int'(fault), 1);

    // leave active, change, re-enter: new baseline
    act_mode = 1'b0;
    fault_clr = 1'b1; run(1); fault_clr = 1'b0;
    bank[1] = bank[1] ^ 16'h0100;
    run(5);
    chk("R10 cleared", int'(fault), 0);
    act_mode = 1'b1;
    run(30);
    chk("R9 recapture no fault", int'(fault), 0);

    // abort mid-sweep, change, resume
    run(3);
    act_mode = 1'b0; run(1);
    bank[4] = bank[4] ^ 16'h8000;
    act_mode = 1'b1;
    run(30);
    chk("R9 abort recapture", int'(fault), 0);

    // monitor disabled by crc_off
    crc_off = 1'b1;
    run(4);
    bank[3] = bank[3] ^ 16'h0040;
    run(25);
    chk("R8 disabled no fault", int'(fault), 0);
    chk("R8 addr idle", int'(rd_addr), 0);
    crc_off = 1'b0;
    run(30);
    chk("R8 reenable no fault", int'(fault), 0);

    // corruption of word 0 while active
    bank[0] = bank[0] ^ 16'h0004;
    run(20);
    chk("R5 mismatch fault", int'(fault), 1);
    chk("R11 status bit", int'(stat_word), 16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule